// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator with Delay Coalescing

This block collects per-queue completion pulses from a DMA engine into one 32-bit status word and drives a single level interrupt toward the processor. Each status bit can be enabled through a 32-bit mask word, and the interrupt line is high while any enabled status bit is set. Software acknowledges events by writing ones to the status word: writing back a value just read clears exactly the bits that were seen.

For each direction, receive and transmit, a coalescing engine can raise a delayed interrupt instead of one per completion. It counts the raw completions of its direction and the timebase ticks that follow the first counted completion. It fires when the completion count reaches a programmed threshold or the tick count reaches a programmed limit, whichever comes first. A firing sets a pair of status bits for that direction and restarts the window. Nothing in this block carries a data stream: the register slave, the event pulses, the tick and the interrupt are all plain control and status pins.

Top module: `dma_irq_coalesce`

## Requirements
- R1: After reset the status, mask and delay words read as zero and `irq` is low.
- R2: A pulse on `tx_done[i]` sets status bit i, and a pulse on `rx_done[j]` sets status bit 16+j, visible after the same clock edge. Unimplemented status bits always read zero.
- R3: A write with `reg_addr`=0 clears every status bit whose `reg_wdata` bit is 1 and leaves the other status bits unchanged.
- R4: When a status bit is set by an event in the same cycle as a write-1-to-clear of that bit, the bit stays set.
- R5: `irq` is high exactly when some status bit and the same mask bit are both 1; the mask is written and read at `reg_addr`=1.
- R6: The delay word is written and read at `reg_addr`=2; bits 15:0 configure receive and bits 31:16 transmit, each half holding an enable in bit 15, a completion threshold in bits 14:8 and a tick limit in bits 7:0. `reg_addr`=3 reads zero.
- R7: With its enable set, a direction whose completions since the window start reach the completion threshold sets its two delayed bits (receive: 31 and 30, transmit: 29 and 28) after the edge on which the reaching completion arrives; completions in one cycle count by their number.
- R8: Ticks count only in cycles after the one holding the first completion of a window; when the tick count reaches a nonzero tick limit, the delayed bits of that direction are set after that edge.
- R9: A threshold or limit of zero disables that condition; with the enable clear the delayed bits never set and the window stays empty.
- R10: A firing empties the window, so the next firing needs a full new count or tick interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word select: 0 status, 1 mask, 2 delay |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word, combinational |
| rx_done | input | RX_Q | Receive-queue completion pulses |
| tx_done | input | TX_Q | Transmit-queue completion pulses |
| tick | input | 1 | Timebase tick for the coalescing windows |
| irq | output | 1 | Level interrupt request |

## Verification
Two functions share a cycle on the status word: an event or a coalescing firing that sets a bit, and a software write that clears the same bit. The bench drives completions together with status writes whose data has that bit set, both in directed steps and within constrained random traffic where acknowledges reuse the modelled status value. A reference model updated per edge predicts that the set wins, and every cycle the status word and `irq` are compared with it.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int DW          = 32;
  localparam int RX_BASE     = 16;
  localparam int TX_BASE     = 0;
  localparam int BIT_RX_COH  = 31;
  localparam int BIT_RX_INT  = 30;
  localparam int BIT_TX_COH  = 29;
  localparam int BIT_TX_INT  = 28;
  localparam int HALF_W      = 16;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_MASK   = 2'd1;
  localparam logic [1:0] A_DELAY  = 2'd2;

  typedef struct packed {
    logic       en;
    logic [6:0] pend_thr;
    logic [7:0] time_thr;
  } coal_cfg_t;
endpackage

// File: rtl/dic_coalescer.sv
module dic_coalescer
  import dic_pkg::*;
#(
  parameter int N_EV  = 4,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] ev,
  input  logic            tick,
  input  coal_cfg_t       cfg,
  output logic            fire
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] ev_cnt_q, tk_cnt_q;
  logic             active_q;
  logic [SUM_W-1:0] ev_inc, ev_sum, tk_sum;
  logic [CNT_W-1:0] ev_sat, tk_sat;
  logic             hit_ev, hit_tk;

  always_comb begin
    ev_inc = '0;
    for (int i = 0; i < N_EV; i++) ev_inc = ev_inc + SUM_W'(ev[i]);
    ev_sum = {1'b0, ev_cnt_q} + ev_inc;
    tk_sum = {1'b0, tk_cnt_q} + SUM_W'(tick && active_q);
    ev_sat = (ev_sum > SUM_W'(CNT_MAX)) ? CNT_MAX : ev_sum[CNT_W-1:0];
    tk_sat = (tk_sum > SUM_W'(CNT_MAX)) ? CNT_MAX : tk_sum[CNT_W-1:0];
    hit_ev = (cfg.pend_thr != '0) && (ev_sum >= SUM_W'(cfg.pend_thr));
    hit_tk = (cfg.time_thr != '0) && (tk_sum >= SUM_W'(cfg.time_thr));
    fire   = cfg.en && (hit_ev || hit_tk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt_q <= '0;
      tk_cnt_q <= '0;
      active_q <= 1'b0;
    end else if (!cfg.en || fire) begin
      ev_cnt_q <= '0;
      tk_cnt_q <= '0;
      active_q <= 1'b0;
    end else begin
      ev_cnt_q <= ev_sat;
      tk_cnt_q <= tk_sat;
      active_q <= active_q || (ev_inc != '0);
    end
  end
endmodule

// File: rtl/dic_status_reg.sv
module dic_status_reg
  import dic_pkg::*;
#(
  parameter logic [DW-1:0] IMPL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set_vec,
  input  logic [DW-1:0] clr_vec,
  output logic [DW-1:0] status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= ((status & ~clr_vec) | set_vec) & IMPL;
  end
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dic_pkg::*;
#(
  parameter int RX_Q  = 2,
  parameter int TX_Q  = 4,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [RX_Q-1:0] rx_done,
  input  logic [TX_Q-1:0] tx_done,
  input  logic            tick,
  output logic            irq
);
  localparam int MAXQ = (RX_Q > TX_Q) ? RX_Q : TX_Q;
  localparam logic [DW-1:0] IMPL_BITS = 32'hF000_0000
      | (((32'h1 << RX_Q) - 32'h1) << RX_BASE)
      | (((32'h1 << TX_Q) - 32'h1) << TX_BASE);

  logic [DW-1:0]   status_q, mask_q, delay_q;
  logic [DW-1:0]   set_vec, clr_vec;
  logic [MAXQ-1:0] dir_ev [2];
  logic [1:0]      dir_fire;

  assign dir_ev[0] = MAXQ'(rx_done);
  assign dir_ev[1] = MAXQ'(tx_done);

  // direction 0 = receive (low half of delay word), 1 = transmit (high half)
  for (genvar d = 0; d < 2; d++) begin : g_dir
    dic_coalescer #(.N_EV(MAXQ), .CNT_W(CNT_W)) u_coal (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (dir_ev[d]),
      .tick  (tick),
      .cfg   (coal_cfg_t'(delay_q[HALF_W*d +: HALF_W])),
      .fire  (dir_fire[d])
    );
  end

  always_comb begin
    set_vec = '0;
    set_vec[RX_BASE +: RX_Q] = rx_done;
    set_vec[TX_BASE +: TX_Q] = tx_done;
    set_vec[BIT_RX_COH] = dir_fire[0];
    set_vec[BIT_RX_INT] = dir_fire[0];
    set_vec[BIT_TX_COH] = dir_fire[1];
    set_vec[BIT_TX_INT] = dir_fire[1];
    clr_vec = (reg_wr && reg_addr == A_STATUS) ? reg_wdata : '0;
  end

  dic_status_reg #(.IMPL(IMPL_BITS)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .status  (status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      delay_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_MASK)  mask_q  <= reg_wdata;
      if (reg_addr == A_DELAY) delay_q <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = status_q;
      A_MASK:   reg_rdata = mask_q;
      A_DELAY:  reg_rdata = delay_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & mask_q);
endmodule

// File: rtl/dic_checker.sv
module dic_checker
  import dic_pkg::*;
#(
  parameter int RX_Q = 2,
  parameter int TX_Q = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_addr,
  input logic [DW-1:0]   reg_wdata,
  input logic [RX_Q-1:0] rx_done,
  input logic [TX_Q-1:0] tx_done,
  input logic [DW-1:0]   status_q,
  input logic [DW-1:0]   mask_q,
  input logic [DW-1:0]   delay_q,
  input logic            irq
);
  assert_raw_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done[0] |=> status_q[TX_BASE]);

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && reg_wdata[TX_BASE] && !tx_done[0])
      |=> !status_q[TX_BASE]);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_STATUS && reg_wdata[RX_BASE] && rx_done[0])
      |=> status_q[RX_BASE]);

  assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0) && (status_q != '0));

  assert_rx_delay_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[BIT_RX_INT]) |-> $past(delay_q[15]));

  assert_tx_delay_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[BIT_TX_INT]) |-> $past(delay_q[31]));

  assert_pair_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[BIT_RX_INT]) |-> status_q[BIT_RX_COH]);
endmodule

bind dma_irq_coalesce dic_checker #(.RX_Q(RX_Q), .TX_Q(TX_Q)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .rx_done   (rx_done),
  .tx_done   (tx_done),
  .status_q  (status_q),
  .mask_q    (mask_q),
  .delay_q   (delay_q),
  .irq       (irq)
);

// File: tb/dma_irq_coalesce_bench.sv
module dma_irq_coalesce_bench;
  localparam int CLK_NS = 20;
  localparam logic [31:0] IMPL = 32'hF003_000F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  rx_done = '0;
  logic [3:0]  tx_done = '0;
  logic        tick = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] m_stat = '0, m_mask = '0, m_dly = '0;
  int m_cnt [2] = '{0, 0};
  int m_tck [2] = '{0, 0};
  bit m_act [2] = '{0, 0};

  always #(CLK_NS/2) clk = ~clk;

  dma_irq_coalesce u_dma_irq_coalesce (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_done(rx_done),
    .tx_done(tx_done), .tick(tick), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > 255) ? 255 : v;
  endfunction

  // reads are combinational; call at a negedge with reg_wr low
  task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
    reg_wr = 1'b0; reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  // one clock of stimulus; the model advances alongside, then outputs are compared
  task automatic step(input string tag, input bit wr, input logic [1:0] a,
                      input logic [31:0] wd, input logic [1:0] rx,
                      input logic [3:0] tx, input bit tk);
    logic [31:0] setv, clrv;
    bit f [2];
    reg_wr = wr; reg_addr = a; reg_wdata = wd;
    rx_done = rx; tx_done = tx; tick = tk;
    for (int d = 0; d < 2; d++) begin
      logic [15:0] c;
      int n, es, ts;
      c  = m_dly[16*d +: 16];
      n  = (d == 0) ? $countones(rx) : $countones(tx);
      es = m_cnt[d] + n;
      ts = m_tck[d] + ((tk && m_act[d]) ? 1 : 0);
      f[d] = c[15] && (((c[14:8] != 0) && es >= int'(c[14:8])) ||
                       ((c[7:0] != 0) && ts >= int'(c[7:0])));
      if (!c[15] || f[d]) begin
        m_cnt[d] = 0; m_tck[d] = 0; m_act[d] = 0;
      end else begin
        m_cnt[d] = sat(es); m_tck[d] = sat(ts); m_act[d] = m_act[d] || (n != 0);
      end
    end
    setv = {f[0], f[0], f[1], f[1], 10'd0, rx, 12'd0, tx};
    clrv = (wr && a == 2'd0) ? wd : 32'd0;
    @(posedge clk);
    m_stat = ((m_stat & ~clrv) | setv) & IMPL;
    if (wr && a == 2'd1) m_mask = wd;
    if (wr && a == 2'd2) m_dly = wd;
    @(negedge clk);
    reg_wr = 1'b0; rx_done = '0; tx_done = '0; tick = 1'b0;
    chk({tag, " irq"}, {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
    rd(2'd0, {tag, " status"}, m_stat);
  endtask

  task automatic idle(input string tag, input int n, input bit tk);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 2'd0, 32'd0, 2'b00, 4'b0000, tk);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rd(2'd0, "R1 status", 32'd0);
    rd(2'd1, "R1 mask", 32'd0);
    rd(2'd2, "R1 delay", 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, "R1 status after release", 32'd0);

    // R6 delay word round trip and unused address
    step("R6 write delay", 1'b1, 2'd2, 32'h8A05_7F11, 2'b00, 4'b0000, 1'b0);
    rd(2'd2, "R6 delay readback", 32'h8A05_7F11);
    rd(2'd3, "R6 address 3", 32'd0);
    step("R6 clear delay", 1'b1, 2'd2, 32'd0, 2'b00, 4'b0000, 1'b0);

    // R2 raw events
    step("R2 raw", 1'b0, 2'd0, 32'd0, 2'b01, 4'b1010, 1'b0);
    rd(2'd0, "R2 raw bits", 32'h0001_000A);
    // R5 mask
    chk("R5 irq masked", {31'd0, irq}, 32'd0);
    step("R5 mask write", 1'b1, 2'd1, 32'h0000_0002, 2'b00, 4'b0000, 1'b0);
    chk("R5 irq enabled", {31'd0, irq}, 32'd1);
    // R3 write-1-to-clear and write of zeros to unimplemented bits
    step("R3 w1c", 1'b1, 2'd0, 32'h0000_0002, 2'b00, 4'b0000, 1'b0);
    rd(2'd0, "R3 bit1 cleared", 32'h0001_0008);
    chk("R5 irq dropped", {31'd0, irq}, 32'd0);
    // R4 set wins over clear
    step("R4 collision", 1'b1, 2'd0, 32'h0001_0008, 2'b01, 4'b1000, 1'b0);
    rd(2'd0, "R4 bits kept", 32'h0001_0008);
    step("R3 clear all", 1'b1, 2'd0, 32'hFFFF_FFFF, 2'b00, 4'b0000, 1'b0);
    rd(2'd0, "R3 all cleared", 32'd0);

    // R7 count threshold 3 on receive
    step("R7 cfg", 1'b1, 2'd2, 32'h0000_8300, 2'b00, 4'b0000, 1'b0);
    step("R7 two events", 1'b0, 2'd0, 32'd0, 2'b11, 4'b0000, 1'b0);
    chk("R7 not yet", {31'd0, reg_rdata[30]}, 32'd0);
    step("R7 third event", 1'b0, 2'd0, 32'd0, 2'b01, 4'b0000, 1'b0);
    chk("R7 rx delayed pair", reg_rdata & 32'hF000_0000, 32'hC000_0000);
    // R10 window restarts
    step("R10 clear", 1'b1, 2'd0, 32'hFFFF_FFFF, 2'b01, 4'b0000, 1'b0);
    step("R10 second", 1'b0, 2'd0, 32'd0, 2'b01, 4'b0000, 1'b0);
    chk("R10 no early fire", reg_rdata & 32'hF000_0000, 32'd0);
    step("R10 third", 1'b0, 2'd0, 32'd0, 2'b01, 4'b0000, 1'b0);
    chk("R10 refire", reg_rdata & 32'hF000_0000, 32'hC000_0000);
    // R4 delayed bit set while being cleared
    step("R4 fire vs clear", 1'b1, 2'd0, 32'hC000_0000, 2'b11, 4'b0000, 1'b0);
    step("R4 fire vs clear b", 1'b1, 2'd0, 32'hC000_0000, 2'b01, 4'b0000, 1'b0);
    chk("R4 delayed kept", reg_rdata & 32'hC000_0000, 32'hC000_0000);

    // R8 tick limit 4 on transmit, count disabled
    step("R8 cfg", 1'b1, 2'd2, 32'h8004_0000, 2'b00, 4'b0000, 1'b0);
    step("R8 clear", 1'b1, 2'd0, 32'hFFFF_FFFF, 2'b00, 4'b0000, 1'b0);
    idle("R8 ticks before event", 3, 1'b1);
    step("R8 event with tick", 1'b0, 2'd0, 32'd0, 2'b00, 4'b0001, 1'b1);
    idle("R8 three ticks", 3, 1'b1);
    chk("R8 not yet", reg_rdata & 32'h3000_0000, 32'd0);
    step("R8 fourth tick", 1'b0, 2'd0, 32'd0, 2'b00, 4'b0000, 1'b1);
    chk("R8 tx delayed pair", reg_rdata & 32'hF000_0000, 32'h3000_0000);

    // R9 disabled and zero thresholds
    step("R9 cfg off", 1'b1, 2'd2, 32'h0101_0101, 2'b00, 4'b0000, 1'b0);
    step("R9 clear", 1'b1, 2'd0, 32'hFFFF_FFFF, 2'b00, 4'b0000, 1'b0);
    for (int i = 0; i < 10; i++) step("R9 disabled", 1'b0, 2'd0, 32'd0, 2'b11, 4'b1111, 1'b1);
    chk("R9 no delayed bits", reg_rdata & 32'hF000_0000, 32'd0);
    step("R9 cfg zero thr", 1'b1, 2'd2, 32'h8000_8000, 2'b00, 4'b0000, 1'b0);
    for (int i = 0; i < 10; i++) step("R9 zero thresholds", 1'b0, 2'd0, 32'd0, 2'b11, 4'b1111, 1'b1);
    chk("R9 zero thr no fire", reg_rdata & 32'hF000_0000, 32'd0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [31:0] wd;
      logic [1:0] a;
      bit wr;
      r  = $urandom % 16;
      wr = (r < 3);
      a  = 2'd0;
      wd = m_stat;
      if (r == 1) begin a = 2'd1; wd = $urandom; end
      if (r == 2) begin
        a = 2'd2;
        wd = {($urandom % 2 == 0), 4'd0, 3'($urandom), 4'd0, 4'($urandom),
              ($urandom % 2 == 0), 4'd0, 3'($urandom), 4'd0, 4'($urandom)};
      end
      if (r == 0 && ($urandom % 2 == 0)) wd = $urandom;
      step("R7 R8 R10 R4 random", wr, a, wd, 2'($urandom), 4'($urandom & $urandom),
           ($urandom % 3 == 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule